// File: doc/BRIEF.md
# Widening Pair Adder/Subtractor

This block takes two 128-bit vector operands, picks narrow elements from each according to a pairing mode, widens each picked element to twice its size, and adds or subtracts the pair. The result is a vector of double-width elements. A source element width of 8, 16, 32 or 64 bits gives 8, 4, 2 or 1 result elements of 16, 32, 64 or 128 bits.

The pairing mode decides which elements meet. In the crossed mode, an odd element of the first operand meets an even element of the second. In the even and odd modes, elements at the same position meet. An extension mode decides how each picked element is widened: both signed, both unsigned, or the first operand unsigned with the second operand signed. Every lane in the selected width runs in parallel, and the result is registered behind one pipeline stage.

Top module: `widen_pair_addsub`

## Requirements
- R1: While `rst` is high, the next clock edge clears `out_valid` and `result` to zero.
- R2: `out_valid` equals `in_valid` from the previous cycle. `result` loads only on a cycle where `in_valid` is high and holds its value otherwise.
- R3: `width` 0, 1, 2 or 3 selects 8, 16, 32 or 64-bit source elements. Result element i, of width 2W, sits at `result[i*2W +: 2W]`. Source element k sits at `src[k*W +: W]`.
- R4: With `mode` 0 (crossed), result element i pairs element 2i+1 of `src_a` with element 2i of `src_b`.
- R5: With `mode` 1 (even), result element i pairs element 2i of both operands.
- R6: With `mode` 2 (odd), result element i pairs element 2i+1 of both operands.
- R7: With `sgn` 0 (signed), both picked elements are sign-extended to 2W bits.
- R8: With `sgn` 1 (unsigned), both picked elements are zero-extended to 2W bits.
- R9: With `sgn` 2 (mixed), the `src_a` element is zero-extended and the `src_b` element is sign-extended.
- R10: With `sub` 0 the lane computes a+b. With `sub` 1 it computes a−b, the `src_a` element minus the `src_b` element. Both wrap modulo 2^(2W) and no overflow is flagged.
- R11: With 64-bit sources, the single 128-bit result comes from one 64-bit element of each operand, chosen by the same pairing rule.
- R12: Reserved encodings load an all-zero `result`: `mode` 3, `sgn` 3, and `sgn` 2 combined with `mode` 0. `out_valid` still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| mode | input | 2 | Pairing: 0 crossed, 1 even, 2 odd |
| sub | input | 1 | 0 add, 1 subtract |
| width | input | 2 | Source element width: 0=8, 1=16, 2=32, 3=64 |
| sgn | input | 2 | Extension: 0 signed, 1 unsigned, 2 mixed |
| src_a | input | 128 | First vector operand |
| src_b | input | 128 | Second vector operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 128 | Registered widened result vector |

## Verification
The hardest cases to reach from the ports are the ones where the extension of a single element changes the upper half of its lane. These cases also depend on the operand picked under the crossed pairing. They only show up when the picked element has its top bit set and the opposite-position element does not.

The stimulus uses two operand patterns. One is an ascending byte ramp and the other is all ones. Each pattern is applied in both operand orders, so the sign bit sits in one source and not the other. A sweep with random data then covers every pairing, extension, width and operation combination, including the reserved ones.

// File: rtl/widen_pair_pkg.sv
package widen_pair_pkg;

  typedef enum logic [1:0] {
    PAIR_CROSS = 2'd0,
    PAIR_EVEN  = 2'd1,
    PAIR_ODD   = 2'd2,
    PAIR_RSVD  = 2'd3
  } pair_mode_e;

  typedef enum logic [1:0] {
    EXT_SIGNED   = 2'd0,
    EXT_UNSIGNED = 2'd1,
    EXT_MIXED    = 2'd2,
    EXT_RSVD     = 2'd3
  } ext_mode_e;

  localparam int NUM_WIDTHS = 4;
  localparam int BASE_ELEM_W = 8;

endpackage

// File: rtl/widen_pair_lane.sv
module widen_pair_lane #(
  parameter int SRC_W = 8,
  localparam int DST_W = 2 * SRC_W
) (
  input  logic [SRC_W-1:0] a_el,
  input  logic [SRC_W-1:0] b_el,
  input  logic             a_sx,
  input  logic             b_sx,
  input  logic             sub,
  output logic [DST_W-1:0] lane_out
);

  logic [DST_W-1:0] a_wide;
  logic [DST_W-1:0] b_wide;

  always_comb begin
    a_wide = {{SRC_W{a_sx & a_el[SRC_W-1]}}, a_el};
    b_wide = {{SRC_W{b_sx & b_el[SRC_W-1]}}, b_el};
    lane_out = sub ? (a_wide - b_wide) : (a_wide + b_wide);
  end

endmodule

// File: rtl/widen_pair_unit.sv
module widen_pair_unit #(
  parameter int VEC_W = 128,
  parameter int SRC_W = 8
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic             a_odd,
  input  logic             b_odd,
  input  logic             a_sx,
  input  logic             b_sx,
  input  logic             sub,
  output logic [VEC_W-1:0] unit_out
);

  localparam int DST_W = 2 * SRC_W;
  localparam int LANES = VEC_W / DST_W;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [SRC_W-1:0] a_pick;
    logic [SRC_W-1:0] b_pick;

    assign a_pick = a_odd ? src_a[(2*gi+1)*SRC_W +: SRC_W]
                          : src_a[(2*gi)*SRC_W +: SRC_W];
    assign b_pick = b_odd ? src_b[(2*gi+1)*SRC_W +: SRC_W]
                          : src_b[(2*gi)*SRC_W +: SRC_W];

    widen_pair_lane #(.SRC_W(SRC_W)) u_lane (
      .a_el    (a_pick),
      .b_el    (b_pick),
      .a_sx    (a_sx),
      .b_sx    (b_sx),
      .sub     (sub),
      .lane_out(unit_out[gi*DST_W +: DST_W])
    );
  end

endmodule

// File: rtl/widen_pair_addsub.sv
module widen_pair_addsub
  import widen_pair_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             sub,
  input  logic [1:0]       width,
  input  logic [1:0]       sgn,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);

  pair_mode_e pair_m;
  ext_mode_e  ext_m;
  logic       a_odd, b_odd, a_sx, b_sx, legal;
  logic [VEC_W-1:0] unit_res [NUM_WIDTHS];
  logic [VEC_W-1:0] picked;

  always_comb begin
    pair_m = pair_mode_e'(mode);
    ext_m  = ext_mode_e'(sgn);
    a_odd  = (pair_m != PAIR_EVEN);
    b_odd  = (pair_m == PAIR_ODD);
    a_sx   = (ext_m == EXT_SIGNED);
    b_sx   = (ext_m == EXT_SIGNED) || (ext_m == EXT_MIXED);
    legal  = (pair_m != PAIR_RSVD) && (ext_m != EXT_RSVD) &&
             !((pair_m == PAIR_CROSS) && (ext_m == EXT_MIXED));
  end

  for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
    widen_pair_unit #(
      .VEC_W(VEC_W),
      .SRC_W(BASE_ELEM_W << gw)
    ) u_unit (
      .src_a   (src_a),
      .src_b   (src_b),
      .a_odd   (a_odd),
      .b_odd   (b_odd),
      .a_sx    (a_sx),
      .b_sx    (b_sx),
      .sub     (sub),
      .unit_out(unit_res[gw])
    );
  end

  always_comb begin
    picked = unit_res[width];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= legal ? picked : '0;
      end
    end
  end

endmodule

// File: rtl/widen_pair_addsub_chk.sv
module widen_pair_addsub_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       mode,
  input logic             sub,
  input logic [1:0]       width,
  input logic [1:0]       sgn,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] src_b,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);

  localparam int HW = VEC_W / 2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'd3 || sgn == 2'd3 || (mode == 2'd0 && sgn == 2'd2)))
    |=> (result == '0));

  assert_wide_even_add_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width == 2'd3 && mode == 2'd1 && sgn == 2'd1 && !sub)
    |=> (result == ({{HW{1'b0}}, $past(src_a[HW-1:0])} +
                    {{HW{1'b0}}, $past(src_b[HW-1:0])})));

  assert_wide_odd_sub_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width == 2'd3 && mode == 2'd2 && sgn == 2'd0 && sub)
    |=> (result == ({{HW{$past(src_a[VEC_W-1])}}, $past(src_a[VEC_W-1:HW])} -
                    {{HW{$past(src_b[VEC_W-1])}}, $past(src_b[VEC_W-1:HW])})));

endmodule

bind widen_pair_addsub widen_pair_addsub_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .mode     (mode),
  .sub      (sub),
  .width    (width),
  .sgn      (sgn),
  .src_a    (src_a),
  .src_b    (src_b),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/widen_pair_addsub_tb.sv
module widen_pair_addsub_tb;

  localparam logic [127:0] PAT  = 128'h0F0E0D0C0B0A09080706050403020100;
  localparam logic [127:0] ONES = '1;

  typedef struct packed {
    logic [1:0]   mode;
    logic         sub;
    logic [1:0]   width;
    logic [1:0]   sgn;
    logic         swap;   // 0: a=PAT b=ONES, 1: a=ONES b=PAT
    logic [127:0] expect_v;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 128'h000D000B000900070005000300010000 | 128'hFFFF}, // R5 R7
    '{2'd1, 1'b0, 2'd0, 2'd1, 1'b0, 128'h010D010B010901070105010301010000 | 128'h00FF}, // R8
    '{2'd2, 1'b1, 2'd0, 2'd0, 1'b0, 128'h0010000E000C000A0008000600040002},              // R6 R10
    '{2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 128'hFF10FF0EFF0CFF0AFF08FF06FF04FF02},              // R4
    '{2'd1, 1'b0, 2'd0, 2'd2, 1'b1, 128'h010D010B010901070105010301010000 | 128'h00FF}, // R9
    '{2'd1, 1'b0, 2'd1, 2'd0, 1'b0, 128'h00000D0B00000907_00000503000000FF},            // R3
    '{2'd2, 1'b1, 2'd2, 2'd1, 1'b0, 128'hFFFFFFFF0F0E0D0D_FFFFFFFF07060505},            // R3 R10
    '{2'd0, 1'b0, 2'd3, 2'd0, 1'b0, 128'h0000000000000000_0F0E0D0C0B0A0907},            // R11
    '{2'd1, 1'b1, 2'd3, 2'd2, 1'b1, 128'h0000000000000000_F8F9FAFBFCFDFEFF},            // R11 R9
    '{2'd3, 1'b0, 2'd0, 2'd0, 1'b0, 128'h0},                                            // R12
    '{2'd0, 1'b0, 2'd1, 2'd2, 1'b0, 128'h0}                                             // R12
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   mode;
  logic         sub;
  logic [1:0]   width;
  logic [1:0]   sgn;
  logic [127:0] src_a;
  logic [127:0] src_b;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  widen_pair_addsub u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .mode     (mode),
    .sub      (sub),
    .width    (width),
    .sgn      (sgn),
    .src_a    (src_a),
    .src_b    (src_b),
    .out_valid(out_valid),
    .result   (result)
  );

  function automatic logic [127:0] ref_calc(input logic [1:0] m, input logic s,
                                            input logic [1:0] w, input logic [1:0] e,
                                            input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r, ea, eb, smask, dmask, lane;
    int sw, n, ia, ib;
    r = '0;
    if (m == 2'd3 || e == 2'd3 || (m == 2'd0 && e == 2'd2)) return '0;
    sw = 8 << w;
    n  = 64 / sw;
    smask = (128'd1 << sw) - 128'd1;
    dmask = (sw == 64) ? '1 : ((128'd1 << (2 * sw)) - 128'd1);
    for (int i = 0; i < n; i++) begin
      ia = (m == 2'd1) ? 2 * i : 2 * i + 1;
      ib = (m == 2'd2) ? 2 * i + 1 : 2 * i;
      ea = (a >> (ia * sw)) & smask;
      eb = (b >> (ib * sw)) & smask;
      if (e == 2'd0 && ea[sw-1]) ea = ea | ~smask;
      if ((e == 2'd0 || e == 2'd2) && eb[sw-1]) eb = eb | ~smask;
      lane = (s ? (ea - eb) : (ea + eb)) & dmask;
      r = r | (lane << (i * 2 * sw));
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic s, input logic [1:0] w,
                        input logic [1:0] e, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] exp_v,
                        input string req);
    @(negedge clk);
    in_valid = 1'b1; mode = m; sub = s; width = w; sgn = e; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R2 valid", {127'd0, out_valid}, 128'd1);
    check(result === exp_v, req, result, exp_v);
  endtask

  initial begin
    logic [127:0] held, ra, rb;
    rst = 1'b1; in_valid = 1'b0; mode = '0; sub = 1'b0; width = '0; sgn = '0;
    src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0 && result === '0, "R1 reset", result, 128'd0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      run_op(VECS[k].mode, VECS[k].sub, VECS[k].width, VECS[k].sgn,
             VECS[k].swap ? ONES : PAT, VECS[k].swap ? PAT : ONES,
             VECS[k].expect_v, $sformatf("R3-table entry %0d", k));
    end

    // R2: idle inputs do not touch result
    run_op(2'd1, 1'b0, 2'd0, 2'd1, PAT, PAT, ref_calc(2'd1, 1'b0, 2'd0, 2'd1, PAT, PAT), "R2 load");
    held = result;
    @(negedge clk);
    src_a = ONES; src_b = ONES; sub = 1'b1; mode = 2'd2;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R2 idle valid", {127'd0, out_valid}, 128'd0);
    check(result === held, "R2 hold", result, held);

    // R12: reserved sign code with valid still produces valid
    run_op(2'd1, 1'b1, 2'd2, 2'd3, PAT, ONES, 128'd0, "R12 sgn3");

    // sweep R4 R5 R6 R7 R8 R9 R10 R11 over every combination
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 3; e++)
        for (int w = 0; w < 4; w++)
          for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++) begin
              ra = {$urandom, $urandom, $urandom, $urandom};
              rb = {$urandom, $urandom, $urandom, $urandom};
              run_op(m[1:0], s[0], w[1:0], e[1:0], ra, rb,
                     ref_calc(m[1:0], s[0], w[1:0], e[1:0], ra, rb),
                     $sformatf("R10 sweep m%0d e%0d w%0d s%0d", m, e, w, s));
            end

    // R1: mid-run reset clears state
    run_op(2'd2, 1'b0, 2'd3, 2'd1, ONES, ONES, ref_calc(2'd2, 1'b0, 2'd3, 2'd1, ONES, ONES), "R11 odd");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && result === '0, "R1 mid-run reset", result, 128'd0);
    rst = 1'b0; in_valid = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule